// File: doc/BRIEF.md
# Synchronous Serial Port with Block Sequencer

This block is an 8-bit clocked serial port that sends and receives at the same time. One byte goes out, most significant bit first, on the data-out line. At the same time one byte comes in on the data-in line. The block can act as master or as slave. As master it drives the serial clock itself. The clock is paced either by a fixed divider of the system clock or by pulses from an external timer overflow. As slave it follows a serial clock that arrives from outside. That clock is first brought into the system clock domain, and its edges are detected before they move the shifter.

A block sequencer handles runs of 1 to 16 bytes with no per-byte help from the host. The host first fills a 16-entry byte buffer through a simple write/read port. It then chooses the byte count and pulses start. The sequencer shifts out each buffer entry in index order. Each received byte is written back into the same entry it was sent from, so at the end the buffer holds the bytes that came in. A busy flag covers the whole run, and a one-cycle done pulse marks its end.

Top module: `sync_shift_xfer`

## Requirements
- R1: After reset: busy=0, done=0, sck_o=1, sck_oe=0, sdo=1, and every buffer entry reads 0x00.
- R2: While idle, sck_oe takes the value of `master` one cycle later (1 = master, drive the clock). During a run sck_oe holds the value it had when the run was launched.
- R3: When master mode uses the divider (use_tmr=0), every low phase and every high phase of sck_o lasts exactly HALF_CYC system clocks (default 4, which gives an 8-clock serial period). sck_o is high whenever the port is idle.
- R4: When master mode uses the timer (use_tmr=1), sck_o toggles once for each system clock in which tmr_ovf is 1 during a run. It never toggles in a cycle where tmr_ovf is 0.
- R5: Each byte goes out MSB first. sdo changes only at a falling serial clock edge, and a new bit appears at every fall.
- R6: sdi is sampled on each rising serial clock edge. The 8 bits received, MSB first, are written into the buffer entry whose byte was being sent.
- R7: len_m1 gives the byte count minus one (0 means 1 byte, 15 means 16 bytes). Bytes go back to back with no extra serial clock phase between them, and entries past the count are left unchanged.
- R8: A start in an idle cycle sets busy on the next cycle. Busy falls on the rising edge of the last bit, and done is high for exactly that one cycle. With the divider this is 64 × (len_m1+1) busy cycles at HALF_CYC=4.
- R9: A start pulse while busy is ignored. The ongoing run keeps its length.
- R10: Host writes to the buffer while busy are ignored.
- R11: In slave mode (master=0), sck_i passes through a two-flop synchroniser and drives the shifter. sck_o stays high and sck_oe stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a run when idle |
| len_m1 | input | 4 | Byte count minus one, taken at launch |
| master | input | 1 | 1 = drive the serial clock, 0 = follow sck_i |
| use_tmr | input | 1 | Master pacing: 1 = timer overflow, 0 = divider |
| tmr_ovf | input | 1 | Timer overflow pulse |
| host_we | input | 1 | Buffer write strobe |
| host_addr | input | 4 | Buffer entry for read and write |
| host_wdata | input | 8 | Buffer write data |
| host_rdata | output | 8 | Buffer entry at host_addr |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock in (slave) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The bench plays the remote device and uses its own byte patterns. It checks both directions, so a swapped bit order or a wrong write-back index shows up as wrong bytes. It measures every serial phase, including the phases across byte boundaries. A design that added a gap between bytes, or that miscounted the divider or the timer pulses, would show a phase of the wrong length or a wrong busy length. The bench runs a single byte, a full 16-byte run and a slave run. It also injects a start and a host write in the middle of a run: a design that accepted either would send extra bytes or corrupt the buffer.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    localparam int unsigned SSX_DATA_W   = 8;
    localparam int unsigned SSX_DEPTH    = 16;
    localparam int unsigned SSX_HALF_CYC = 4;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic master;
        logic use_tmr;
    } port_cfg_t;

    function automatic logic is_last(input logic [7:0] idx, input logic [7:0] last);
        return idx == last;
    endfunction

endpackage

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
    parameter int unsigned HALF_CYC = 4,
    localparam int unsigned CW = $clog2(HALF_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic cfg_master,
    input  logic cfg_tmr,
    input  logic tmr_ovf,
    input  logic sck_i,
    output logic sck_o,
    output logic rise,
    output logic fall
);
    logic [CW-1:0] div_q;
    logic          sck_q;
    logic [2:0]    sync_q;
    logic          cpu_tick;
    logic          tick;
    logic          m_rise, m_fall, s_rise, s_fall;

    assign cpu_tick = (div_q == CW'(HALF_CYC - 1));
    assign tick     = run && (cfg_tmr ? tmr_ovf : cpu_tick);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (cpu_tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            sck_q <= 1'b1;
        end else if (cfg_master && tick) begin
            sck_q <= ~sck_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 3'b111;
        end else begin
            sync_q <= {sync_q[1:0], sck_i};
        end
    end

    assign m_rise = cfg_master && tick && !sck_q;
    assign m_fall = cfg_master && tick && sck_q;
    assign s_rise = !cfg_master && run && sync_q[1] && !sync_q[2];
    assign s_fall = !cfg_master && run && !sync_q[1] && sync_q[2];

    assign rise  = m_rise || s_rise;
    assign fall  = m_fall || s_fall;
    assign sck_o = sck_q;

endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned BW = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              rise,
    input  logic              fall,
    input  logic              sdi,
    output logic              sdo,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] sreg_q;
    logic [BW-1:0]     bit_q;
    logic              sdo_q;

    assign byte_done = rise && (bit_q == BW'(DATA_W - 1));
    assign rx_byte   = {sreg_q[DATA_W-2:0], sdi};
    assign sdo       = sdo_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg_q <= '0;
            bit_q  <= '0;
        end else if (load) begin
            sreg_q <= load_data;
            bit_q  <= '0;
        end else if (rise) begin
            sreg_q <= {sreg_q[DATA_W-2:0], sdi};
            bit_q  <= bit_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sdo_q <= 1'b1;
        end else if (fall) begin
            sdo_q <= sreg_q[DATA_W-1];
        end
    end

endmodule

// File: rtl/ssx_buffer.sv
module ssx_buffer #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [AW-1:0]     host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_waddr,
    input  logic [DATA_W-1:0] eng_wdata,
    input  logic [AW-1:0]     eng_raddr,
    output logic [DATA_W-1:0] eng_rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[g] <= '0;
            end else if (eng_we && eng_waddr == AW'(g)) begin
                mem_q[g] <= eng_wdata;
            end else if (host_we && host_addr == AW'(g)) begin
                mem_q[g] <= host_wdata;
            end
        end
    end

    assign host_rdata = mem_q[host_addr];
    assign eng_rdata  = mem_q[eng_raddr];

endmodule

// File: rtl/sync_shift_xfer.sv
module sync_shift_xfer
    import ssx_pkg::*;
#(
    parameter int unsigned DATA_W   = SSX_DATA_W,
    parameter int unsigned DEPTH    = SSX_DEPTH,
    parameter int unsigned HALF_CYC = SSX_HALF_CYC,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [IDX_W-1:0]  len_m1,
    input  logic              master,
    input  logic              use_tmr,
    input  logic              tmr_ovf,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              busy,
    output logic              done,
    output logic              sck_o,
    output logic              sck_oe,
    input  logic              sck_i,
    input  logic              sdi,
    output logic              sdo
);
    seq_state_e        state_q;
    port_cfg_t         cfg_q;
    logic [IDX_W-1:0]  idx_q, last_q;
    logic              done_q;
    logic              start_ok, last_byte, load;
    logic              rise, fall, byte_done;
    logic              cfg_master, cfg_tmr;
    logic [IDX_W-1:0]  eng_raddr;
    logic [DATA_W-1:0] eng_rdata, rx_byte;

    assign start_ok   = start && (state_q == SEQ_IDLE);
    assign last_byte  = is_last(8'(idx_q), 8'(last_q));
    assign load       = start_ok || (byte_done && !last_byte);
    assign eng_raddr  = start_ok ? '0 : IDX_W'(idx_q + 1'b1);
    assign cfg_master = cfg_q.master;
    assign cfg_tmr    = cfg_q.use_tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            cfg_q   <= '0;
            idx_q   <= '0;
            last_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == SEQ_IDLE) begin
                cfg_q <= '{master: master, use_tmr: use_tmr};
            end
            if (start_ok) begin
                state_q <= SEQ_RUN;
                idx_q   <= '0;
                last_q  <= len_m1;
            end else if (byte_done) begin
                if (last_byte) begin
                    state_q <= SEQ_IDLE;
                    done_q  <= 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    assign busy   = (state_q == SEQ_RUN);
    assign done   = done_q;
    assign sck_oe = cfg_master;

    ssx_clkgen #(.HALF_CYC(HALF_CYC)) i_clkgen (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .cfg_master (cfg_master),
        .cfg_tmr    (cfg_tmr),
        .tmr_ovf    (tmr_ovf),
        .sck_i      (sck_i),
        .sck_o      (sck_o),
        .rise       (rise),
        .fall       (fall)
    );

    ssx_shifter #(.DATA_W(DATA_W)) i_shifter (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_data (eng_rdata),
        .rise      (rise),
        .fall      (fall),
        .sdi       (sdi),
        .sdo       (sdo),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    ssx_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_buffer (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we && !busy),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_we     (byte_done),
        .eng_waddr  (idx_q),
        .eng_wdata  (rx_byte),
        .eng_raddr  (eng_raddr),
        .eng_rdata  (eng_rdata)
    );

endmodule

// File: rtl/ssx_checker.sv
module ssx_checker (
    input logic clk,
    input logic rst,
    input logic start,
    input logic busy,
    input logic done,
    input logic sck_o,
    input logic sck_oe,
    input logic sdo,
    input logic tmr_ovf,
    input logic cfg_tmr
);
    p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_at_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_start_launch_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_idle_sck_high_r3: assert property (@(posedge clk) disable iff (rst)
        !busy |-> sck_o);

    p_tmr_pace_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && sck_oe && cfg_tmr && !tmr_ovf) |=> $stable(sck_o));

    p_sdo_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (sck_oe && !$stable(sdo)) |-> $fell(sck_o));

    p_oe_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sck_oe));

    p_slave_sck_r11: assert property (@(posedge clk) disable iff (rst)
        !sck_oe |-> sck_o);

endmodule

bind sync_shift_xfer ssx_checker i_ssx_checker (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .sck_o   (sck_o),
    .sck_oe  (sck_oe),
    .sdo     (sdo),
    .tmr_ovf (tmr_ovf),
    .cfg_tmr (cfg_tmr)
);

// File: tb/test_sync_shift_xfer.sv
`timescale 1ns/1ps
module test_sync_shift_xfer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [3:0] len_m1 = '0;
    logic       master = 1'b1;
    logic       use_tmr = 1'b0;
    logic       tmr_ovf = 1'b0;
    logic       host_we = 1'b0;
    logic [3:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       busy, done, sck_o, sck_oe, sdo;
    logic       sck_i = 1'b1;
    logic       sdi = 1'b1;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sync_shift_xfer i_sync_shift_xfer (
        .clk(clk), .rst(rst), .start(start), .len_m1(len_m1), .master(master),
        .use_tmr(use_tmr), .tmr_ovf(tmr_ovf), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy), .done(done),
        .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i), .sdi(sdi), .sdo(sdo)
    );

    // remote device model and monitors
    logic [7:0] peer_tx [16];
    logic [7:0] peer_rx [16];
    int pbyte = 0, pbit = 0;
    int busy_cnt = 0, done_cnt = 0, edge_cnt = 0, ph_cnt = 0, ph_min = 1000, ph_max = 0;
    logic mon_prev = 1'b1;
    logic tmr_en = 1'b0;
    int tcnt = 0;

    always @(negedge clk) begin
        logic obs;
        obs = sck_oe ? sck_o : sck_i;
        if (busy) busy_cnt++;
        if (done) done_cnt++;
        ph_cnt++;
        if (obs != mon_prev) begin
            if (edge_cnt > 0) begin
                if (ph_cnt < ph_min) ph_min = ph_cnt;
                if (ph_cnt > ph_max) ph_max = ph_cnt;
            end
            ph_cnt = 0;
            edge_cnt++;
            if (!obs) begin
                if (pbyte < 16) sdi = peer_tx[pbyte][7 - pbit];
            end else if (pbyte < 16) begin
                peer_rx[pbyte] = {peer_rx[pbyte][6:0], sdo};
                pbit++;
                if (pbit == 8) begin
                    pbit = 0;
                    pbyte++;
                end
            end
        end
        mon_prev = obs;
    end

    always @(negedge clk) begin
        if (tmr_en) begin
            tcnt++;
            tmr_ovf = (tcnt % 3 == 0);
        end else begin
            tmr_ovf = 1'b0;
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic buf_write(input int a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = 4'(a); host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic buf_check(input int a, input logic [7:0] exp, input string req);
        @(negedge clk);
        host_addr = 4'(a);
        #1;
        check(host_rdata == exp, req, host_rdata, exp);
    endtask

    task automatic kick(input int lm1);
        @(negedge clk);
        busy_cnt = 0; done_cnt = 0; edge_cnt = 0; ph_min = 1000; ph_max = 0;
        pbyte = 0; pbit = 0;
        for (int i = 0; i < 16; i++) peer_rx[i] = '0;
        len_m1 = 4'(lm1); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(done == 1'b0, "R1 done", done, 0);
        check(sck_o == 1'b1, "R1 sck_o", sck_o, 1);
        check(sdo == 1'b1, "R1 sdo", sdo, 1);
        buf_check(7, 8'h00, "R1 buffer");
    endtask

    task automatic t_oe_follow();
        @(negedge clk); master = 1'b0;
        repeat (2) @(negedge clk);
        check(sck_oe == 1'b0, "R2 oe slave", sck_oe, 0);
        master = 1'b1;
        repeat (2) @(negedge clk);
        check(sck_oe == 1'b1, "R2 oe master", sck_oe, 1);
    endtask

    task automatic t_master_cpu();
        logic [7:0] tx [4] = '{8'hA5, 8'h3C, 8'hF0, 8'h01};
        logic [7:0] px [3] = '{8'h5A, 8'hC3, 8'h0F};
        for (int i = 0; i < 4; i++) buf_write(i, tx[i]);
        for (int i = 0; i < 3; i++) peer_tx[i] = px[i];
        master = 1'b1; use_tmr = 1'b0;
        kick(2);
        check(sck_oe == 1'b1, "R2 oe during run", sck_oe, 1);
        wait_done();
        check(ph_min == 4 && ph_max == 4, "R3 phase length", ph_max * 256 + ph_min, 4 * 256 + 4);
        check(busy_cnt == 192, "R8 busy cycles", busy_cnt, 192);
        check(done_cnt == 1, "R8 done pulse", done_cnt, 1);
        for (int i = 0; i < 3; i++)
            check(peer_rx[i] == tx[i], "R5 msb-first out", peer_rx[i], tx[i]);
        for (int i = 0; i < 3; i++) buf_check(i, px[i], "R6 rx write-back");
        buf_check(3, 8'h01, "R7 entry past count");
    endtask

    task automatic t_full_length();
        for (int i = 0; i < 16; i++) begin
            buf_write(i, 8'(i * 37 + 5));
            peer_tx[i] = ~8'(i * 11);
        end
        kick(15);
        wait_done();
        check(busy_cnt == 1024, "R7 sixteen bytes busy", busy_cnt, 1024);
        check(pbyte == 16, "R7 byte count", pbyte, 16);
        check(ph_max == 4, "R7 no gap between bytes", ph_max, 4);
        for (int i = 0; i < 16; i++)
            check(peer_rx[i] == 8'(i * 37 + 5), "R5 full out", peer_rx[i], 8'(i * 37 + 5));
        for (int i = 0; i < 16; i++) buf_check(i, ~8'(i * 11), "R6 full in");
    endtask

    task automatic t_single();
        buf_write(0, 8'h81);
        buf_write(1, 8'h77);
        peer_tx[0] = 8'h18;
        kick(0);
        wait_done();
        check(busy_cnt == 64, "R7 single busy", busy_cnt, 64);
        check(pbyte == 1, "R7 single count", pbyte, 1);
        check(peer_rx[0] == 8'h81, "R5 single out", peer_rx[0], 8'h81);
        buf_check(0, 8'h18, "R6 single in");
        buf_check(1, 8'h77, "R7 single untouched");
    endtask

    task automatic t_ignored_while_busy();
        buf_write(0, 8'hC6);
        buf_write(5, 8'h42);
        peer_tx[0] = 8'h99;
        kick(0);
        repeat (20) @(negedge clk);
        len_m1 = 4'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        host_we = 1'b1; host_addr = 4'd5; host_wdata = 8'hEE;
        @(negedge clk);
        host_we = 1'b0;
        wait_done();
        check(busy_cnt == 64, "R9 length kept", busy_cnt, 64);
        check(pbyte == 1, "R9 bytes sent", pbyte, 1);
        check(done_cnt == 1, "R9 one done", done_cnt, 1);
        check(busy == 1'b0, "R9 idle after", busy, 0);
        buf_check(5, 8'h42, "R10 host write ignored");
        buf_check(0, 8'h99, "R6 rx kept");
    endtask

    task automatic t_timer();
        buf_write(0, 8'h96);
        buf_write(1, 8'h2B);
        peer_tx[0] = 8'h4D; peer_tx[1] = 8'hE1;
        master = 1'b1; use_tmr = 1'b1; tmr_en = 1'b0;
        kick(1);
        repeat (30) @(negedge clk);
        check(sck_o == 1'b1 && busy == 1'b1, "R4 no toggle without overflow", {sck_o, busy}, 2'b11);
        tmr_en = 1'b1;
        wait_done();
        tmr_en = 1'b0;
        check(ph_min == 3 && ph_max == 3, "R4 phase per overflow", ph_max * 256 + ph_min, 3 * 256 + 3);
        check(peer_rx[0] == 8'h96 && peer_rx[1] == 8'h2B, "R4 timer data out",
              {peer_rx[0], peer_rx[1]}, 16'h962B);
        buf_check(0, 8'h4D, "R6 timer in 0");
        buf_check(1, 8'hE1, "R6 timer in 1");
        use_tmr = 1'b0;
    endtask

    task automatic t_slave();
        buf_write(0, 8'h3E);
        buf_write(1, 8'hD4);
        peer_tx[0] = 8'hB7; peer_tx[1] = 8'h29;
        master = 1'b0;
        repeat (2) @(negedge clk);
        check(sck_oe == 1'b0, "R11 oe low", sck_oe, 0);
        kick(1);
        for (int b = 0; b < 16; b++) begin
            @(posedge clk); #1 sck_i = 1'b0;
            repeat (6) @(posedge clk);
            #1 sck_i = 1'b1;
            repeat (5) @(posedge clk);
        end
        wait_done();
        check(done_cnt == 1, "R11 slave done", done_cnt, 1);
        check(sck_o == 1'b1, "R11 sck_o high", sck_o, 1);
        check(peer_rx[0] == 8'h3E && peer_rx[1] == 8'hD4, "R11 slave out",
              {peer_rx[0], peer_rx[1]}, 16'h3ED4);
        buf_check(0, 8'hB7, "R11 slave in 0");
        buf_check(1, 8'h29, "R11 slave in 1");
        master = 1'b1;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_oe_follow();
        t_master_cpu();
        t_full_length();
        t_single();
        t_ignored_while_busy();
        t_timer();
        t_slave();
        report();
    end

endmodule